// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block watches one infrared receiver line and turns its waveform into a compact stream of bytes. Each byte describes one run: whether the line was in the pulse state or the space state, and for how many sample periods. A receive FIFO outside the block stores the bytes. Software or a protocol decoder later rebuilds the timing from them.

The line goes through a two-stage synchronizer, with an optional polarity inversion ahead of it. It is then sampled once every `DIV_RATIO` module clocks. A change of level counts only once it has lasted a programmable number of samples. A shorter excursion is absorbed into the run around it. When the line has stayed in space long enough, the block writes the space run so far and marks the end of the packet. It then stays silent until a new pulse is accepted.

Top module: `irRunEncoder`

## Requirements
- R1: Encoding runs only while `globalEn`, `rxEn` are both 1 and `modeSel` equals 2'b11. At any other time no byte or packet-end is produced, and all run state returns to the waiting-for-pulse state.
- R2: The line is taken as `irIn` XOR `invertIn` through two synchronizing flops. It is sampled on one clock out of every `DIV_RATIO` clocks while the block is enabled. With `invertIn`=1 an active-low line gives the same byte stream that the active-high line gives with `invertIn`=0.
- R3: Each byte written carries the run level in bit 7 (1 = pulse, 0 = space) and the run length minus one, in samples, in bits 6:0.
- R4: A run of more than 128 samples is written as one byte with length code 127 for every full 128 samples, in the same level. Any remainder follows as its own byte. A run that is an exact multiple of 128 writes no zero-length byte.
- R5: A change of level is accepted after `noiseThr` consecutive samples at the new level, and a value of 0 acts as 1. A shorter excursion is added, sample for sample, to the length of the run it interrupts.
- R6: When a space run reaches `idleThr` samples, its pending length is written as a space byte and `pktEnd` is high for exactly that one clock. A value of 0 in `idleThr` disables the packet end.
- R7: After enable and after every packet end, nothing is written until a pulse is accepted. Space samples and rejected short pulses in that state produce no bytes.
- R8: `wrEn` is high for a single clock, one clock after the sample that caused the write, and never on two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalEn | input | 1 | Block-wide enable |
| rxEn | input | 1 | Receive path enable |
| modeSel | input | 2 | Operating mode; 2'b11 selects run-length encoding |
| invertIn | input | 1 | Invert the line before sampling |
| noiseThr | input | NOISE_W | Minimum accepted run length in samples |
| idleThr | input | IDLE_W | Space length that ends a packet; 0 disables |
| irIn | input | 1 | Asynchronous receiver line |
| wrEn | output | 1 | Write strobe toward the receive FIFO |
| wrData | output | 8 | Run byte: level in bit 7, length minus one in bits 6:0 |
| pktEnd | output | 1 | One-clock packet-end event, aligned with the final space byte |

## Verification
The central test sweeps the leading pulse length from 1 to 140 samples and adds a few lengths around 256 and 384. A short space and a second pulse of varying length follow, and a long space closes the packet. This separates the off-by-one length code, the exact 128-sample chunk boundary and the order of pulse and space bytes. Noise patterns place glitches shorter than the threshold inside a pulse and right after a packet end. They show whether the glitch is merged into the run or dropped, and a zero threshold is shown to act like one. Further patterns cover a space chunked before the idle flush, a disabled idle threshold, inverted polarity, and line activity while the mode or an enable is off. Together they show that only the enable decode gates the encoder.

// File: rtl/irEnc_pkg.sv
package irEnc_pkg;

  // Status flags the datapath reports to the control each clock.
  typedef struct packed {
    logic tick;     // sample instant
    logic smp;      // synchronized, polarity-corrected sample
    logic candOk;   // the current opposite-level streak reaches the noise threshold
    logic idleHit;  // continuing the space run reaches the idle threshold
    logic runZero;  // no pending samples in the current run
  } dpStat_t;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic clear;    // block disabled: drop all run state
    logic candClr;  // discard opposite-level streak
    logic candInc;  // extend opposite-level streak
    logic merge;    // sample continues the run, absorb any streak
    logic accept;   // level change accepted, start new run
    logic emitPrev; // with accept: write the finished run
    logic flush;    // idle reached: write space run, end packet
    logic level;    // level of the run being written
  } ctlStrb_t;

endpackage

// File: rtl/irEncData.sv
module irEncData
  import irEnc_pkg::*;
#(
  parameter int DIV_RATIO = 64,
  parameter int NOISE_W   = 6,
  parameter int IDLE_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               active,
  input  logic               invertIn,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               irIn,
  input  ctlStrb_t           strb,
  output dpStat_t            stat,
  output logic               wrEn,
  output logic [7:0]         wrData,
  output logic               pktEnd
);

  localparam int DIV_W  = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
  localparam int RUN_W  = 8;
  localparam int SUM_W  = RUN_W + 1;
  localparam int CAND_W = NOISE_W + 1;
  localparam int IDL_W1 = IDLE_W + 1;
  localparam logic [SUM_W-1:0] CHUNK = SUM_W'(128);

  logic [1:0]         syncQ;
  logic [DIV_W-1:0]   divCnt;
  logic [NOISE_W-1:0] candLen;
  logic [RUN_W-1:0]   runLen;
  logic [IDLE_W-1:0]  idleCnt;

  logic [CAND_W-1:0]  candNext;
  logic [CAND_W-1:0]  thrEff;
  logic [SUM_W-1:0]   sumMerge;
  logic [IDL_W1-1:0]  idleSum;
  logic [IDLE_W-1:0]  idleNext;
  logic [RUN_W-1:0]   runDec;
  logic [SUM_W-1:0]   sumDec;
  logic [6:0]         flushCode;

  // Two-flop synchronizer on the polarity-corrected line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], irIn ^ invertIn};
  end

  // Sample-rate divider.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (!active)          divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + DIV_W'(1);
  end

  always_comb begin
    candNext  = {1'b0, candLen} + CAND_W'(1);
    thrEff    = (noiseThr == '0) ? CAND_W'(1) : {1'b0, noiseThr};
    sumMerge  = {1'b0, runLen} + SUM_W'(candNext);
    idleSum   = {1'b0, idleCnt} + IDL_W1'(candNext);
    idleNext  = idleSum[IDLE_W] ? '1 : idleSum[IDLE_W-1:0];
    runDec    = runLen - RUN_W'(1);
    sumDec    = sumMerge - SUM_W'(1);
    flushCode = (sumMerge >= CHUNK) ? 7'h7f : sumDec[6:0];

    stat.tick    = active && (divCnt == DIV_LAST);
    stat.smp     = syncQ[1];
    stat.candOk  = candNext >= thrEff;
    stat.idleHit = (idleThr != '0) && (idleNext >= idleThr);
    stat.runZero = (runLen == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candLen <= '0;
      runLen  <= '0;
      idleCnt <= '0;
      wrEn    <= 1'b0;
      wrData  <= '0;
      pktEnd  <= 1'b0;
    end else begin
      wrEn   <= 1'b0;
      pktEnd <= 1'b0;
      if (strb.clear) begin
        candLen <= '0;
        runLen  <= '0;
        idleCnt <= '0;
      end else if (strb.candClr) begin
        candLen <= '0;
      end else if (strb.candInc) begin
        candLen <= candNext[NOISE_W-1:0];
      end else if (strb.merge) begin
        candLen <= '0;
        idleCnt <= idleNext;
        if (sumMerge >= CHUNK) begin
          wrEn   <= 1'b1;
          wrData <= {strb.level, 7'h7f};
          runLen <= RUN_W'(sumMerge - CHUNK);
        end else begin
          runLen <= sumMerge[RUN_W-1:0];
        end
      end else if (strb.accept) begin
        if (strb.emitPrev) begin
          wrEn   <= 1'b1;
          wrData <= {strb.level, runDec[6:0]};
        end
        runLen  <= RUN_W'(candNext);
        idleCnt <= IDLE_W'(candNext);
        candLen <= '0;
      end else if (strb.flush) begin
        wrEn    <= 1'b1;
        wrData  <= {1'b0, flushCode};
        pktEnd  <= 1'b1;
        runLen  <= '0;
        candLen <= '0;
        idleCnt <= '0;
      end
    end
  end

  // R8: a write only follows a sample instant, and lasts one clock.
  p_write_after_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(stat.tick));
  p_write_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
  // R6: packet end coincides with a space byte.
  p_pktend_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |-> (wrEn && !wrData[7]));
  // R1: disabled block stays silent.
  p_quiet_disabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!wrEn && !pktEnd));
  // R4: the pending run never holds a full chunk between samples.
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    runLen < 8'd128);

endmodule

// File: rtl/irEncCtl.sv
module irEncCtl
  import irEnc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     active,
  input  dpStat_t  stat,
  output ctlStrb_t strb
);

  logic curLevel;  // level of the run being measured
  logic idleSt;    // waiting for the first pulse of a packet

  always_comb begin
    strb       = '0;
    strb.level = curLevel;
    strb.clear = !active;
    if (active && stat.tick) begin
      if (idleSt) begin
        if (stat.smp) begin
          if (stat.candOk) strb.accept  = 1'b1;
          else             strb.candInc = 1'b1;
        end else begin
          strb.candClr = 1'b1;
        end
      end else if (stat.smp == curLevel) begin
        if (!curLevel && stat.idleHit) strb.flush = 1'b1;
        else                           strb.merge = 1'b1;
      end else if (stat.candOk) begin
        strb.accept   = 1'b1;
        strb.emitPrev = !stat.runZero;
      end else begin
        strb.candInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= 1'b0;
      idleSt   <= 1'b1;
    end else if (!active) begin
      curLevel <= 1'b0;
      idleSt   <= 1'b1;
    end else if (strb.accept) begin
      curLevel <= stat.smp;
      idleSt   <= 1'b0;
    end else if (strb.flush) begin
      idleSt   <= 1'b1;
    end
  end

  // R7: the waiting state always measures from the space level.
  p_idle_is_space_r7: assert property (@(posedge clk) disable iff (!rstN)
    idleSt |-> !curLevel);
  // R6: a packet closes only out of a space run, and then waits.
  p_flush_then_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (idleSt && !curLevel));
  // R5: at most one action per sample.
  p_one_action_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.candClr, strb.candInc, strb.merge, strb.accept, strb.flush}));
  // R7: nothing written when a packet starts.
  p_no_emit_on_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (idleSt && strb.accept) |-> !strb.emitPrev);

endmodule

// File: rtl/irRunEncoder.sv
module irRunEncoder
  import irEnc_pkg::*;
#(
  parameter int DIV_RATIO = 64,
  parameter int NOISE_W   = 6,
  parameter int IDLE_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic               rxEn,
  input  logic [1:0]         modeSel,
  input  logic               invertIn,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               irIn,
  output logic               wrEn,
  output logic [7:0]         wrData,
  output logic               pktEnd
);

  localparam logic [1:0] MODE_RUNLEN = 2'b11;

  logic     active;
  dpStat_t  stat;
  ctlStrb_t strb;

  assign active = globalEn && rxEn && (modeSel == MODE_RUNLEN);

  irEncData #(
    .DIV_RATIO(DIV_RATIO),
    .NOISE_W  (NOISE_W),
    .IDLE_W   (IDLE_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .active  (active),
    .invertIn(invertIn),
    .noiseThr(noiseThr),
    .idleThr (idleThr),
    .irIn    (irIn),
    .strb    (strb),
    .stat    (stat),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .pktEnd  (pktEnd)
  );

  irEncCtl uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .active(active),
    .stat  (stat),
    .strb  (strb)
  );

endmodule

// File: tb/sim_irRunEncoder.sv
module sim_irRunEncoder;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       globalEn, rxEn, invertIn, irIn;
  logic [1:0] modeSel;
  logic [5:0] noiseThr;
  logic [7:0] idleThr;
  logic       wrEn, pktEnd;
  logic [7:0] wrData;

  int nChecks = 0;
  int nFail   = 0;
  int burstErr = 0;
  bit prevWr = 1'b0;
  bit done = 1'b0;
  logic [8:0] gotQ[$];
  logic [8:0] expQ[$];

  always #10 clk = ~clk;

  irRunEncoder #(.DIV_RATIO(DIV), .NOISE_W(6), .IDLE_W(8)) u0 (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .rxEn(rxEn),
    .modeSel(modeSel), .invertIn(invertIn), .noiseThr(noiseThr),
    .idleThr(idleThr), .irIn(irIn), .wrEn(wrEn), .wrData(wrData),
    .pktEnd(pktEnd)
  );

  // Capture every write and packet end (0x100 marks a packet end).
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) gotQ.push_back({1'b0, wrData});
      if (pktEnd) gotQ.push_back(9'h100);
      if (wrEn && prevWr) burstErr++;
      prevWr = wrEn;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putSample(input bit b);
    irIn = b ^ invertIn;
    repeat (DIV) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic putRun(input bit b, input int n);
    for (int i = 0; i < n; i++) putSample(b);
  endtask

  task automatic expRun(input bit lvl, input int len);
    int rem = len;
    while (rem >= 128) begin
      expQ.push_back({1'b0, lvl, 7'h7f});
      rem -= 128;
    end
    if (rem > 0) expQ.push_back({1'b0, lvl, 7'(rem - 1)});
  endtask

  task automatic expEnd();
    expQ.push_back({1'b0, 1'b0, 7'(idleThr - 8'd1)});
    expQ.push_back(9'h100);
  endtask

  task automatic compareQ(input string req);
    int n;
    repeat (2 * DIV) @(posedge clk);
    @(negedge clk);
    chk(gotQ.size() == expQ.size(), req, gotQ.size(), expQ.size());
    n = (gotQ.size() < expQ.size()) ? gotQ.size() : expQ.size();
    for (int i = 0; i < n; i++) chk(gotQ[i] == expQ[i], req, gotQ[i], expQ[i]);
    gotQ.delete();
    expQ.delete();
  endtask

  task automatic finishRun();
    chk(burstErr == 0, "R8 single-clock write", burstErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; globalEn = 1'b0; rxEn = 1'b0; modeSel = 2'b00;
    invertIn = 1'b0; irIn = 1'b0; noiseThr = 6'd1; idleThr = 8'd20;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(wrEn == 1'b0 && pktEnd == 1'b0, "R1 reset outputs", {wrEn, pktEnd}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: mode not selected, activity ignored.
    globalEn = 1'b1; rxEn = 1'b1; modeSel = 2'b01;
    putRun(1, 30); putRun(0, 30);
    compareQ("R1 mode off");
    modeSel = 2'b11;

    // R3 R4: sweep of pulse lengths, with short space and second pulse.
    for (int p = 1; p <= 140; p++) begin
      int s = 1 + (p % 7);
      int q = 1 + (p % 11);
      putRun(1, p); putRun(0, s); putRun(1, q); putRun(0, 22);
      expRun(1, p); expRun(0, s); expRun(1, q); expEnd();
    end
    compareQ("R3 R4 pulse sweep");
    foreach (expQ[i]) ; // no-op keeps queue usage uniform
    for (int k = 0; k < 7; k++) begin
      int p;
      case (k)
        0: p = 200; 1: p = 255; 2: p = 256; 3: p = 257;
        4: p = 383; 5: p = 384; default: p = 385;
      endcase
      putRun(1, p); putRun(0, 3); putRun(1, 2); putRun(0, 21);
      expRun(1, p); expRun(0, 3); expRun(1, 2); expEnd();
      compareQ("R4 long pulse chunks");
    end

    // R5: glitch inside a pulse merges, space accepted after 3 samples.
    noiseThr = 6'd3;
    putRun(1, 10); putRun(0, 2); putRun(1, 10); putRun(0, 25);
    expQ.push_back({1'b0, 1'b1, 7'd21}); expEnd();
    compareQ("R5 glitch merge");
    // R5 R7: short pulse after packet end is rejected.
    putRun(1, 2); putRun(0, 25);
    compareQ("R5 R7 short pulse dropped");
    // R5: zero threshold acts as one.
    noiseThr = 6'd0;
    putRun(1, 5); putRun(0, 3); putRun(1, 2); putRun(0, 21);
    expRun(1, 5); expRun(0, 3); expRun(1, 2); expEnd();
    compareQ("R5 zero threshold");
    noiseThr = 6'd1;

    // R6 R4: idle threshold above a chunk.
    idleThr = 8'd200;
    putRun(1, 5); putRun(0, 210);
    expRun(1, 5); expQ.push_back({1'b0, 1'b0, 7'h7f}); expEnd();
    compareQ("R6 space chunk then flush");

    // R6: disabled idle threshold, then re-armed.
    idleThr = 8'd0;
    putRun(1, 5); putRun(0, 300); putRun(1, 3);
    expRun(1, 5); expRun(0, 300);
    idleThr = 8'd20;
    putRun(0, 22);
    expRun(1, 3); expEnd();
    compareQ("R6 idle disabled");

    // R2: inverted polarity gives the same stream.
    invertIn = 1'b1;
    irIn = 1'b1;
    for (int p = 3; p <= 6; p++) begin
      putRun(1, p); putRun(0, 4); putRun(1, 7); putRun(0, 21);
      expRun(1, p); expRun(0, 4); expRun(1, 7); expEnd();
    end
    compareQ("R2 inverted line");
    invertIn = 1'b0;
    irIn = 1'b0;

    // R1 R7: disabling mid-pulse clears state; nothing follows re-enable.
    putRun(1, 50);
    globalEn = 1'b0;
    repeat (3 * DIV) @(posedge clk);
    @(negedge clk);
    irIn = 1'b0;
    globalEn = 1'b1;
    putRun(0, 25);
    compareQ("R1 R7 disable mid-run");
    rxEn = 1'b0;
    putRun(1, 10); putRun(0, 10);
    rxEn = 1'b1;
    putRun(0, 25);
    compareQ("R1 rx enable off");

    done = 1'b1;
    finishRun();
  end

endmodule